// File: doc/BRIEF.md
# Modulo Timer Counter with Overflow Interlock

A 16-bit up-counter that advances on a timer-clock enable and wraps at a programmable modulo value. When the count reaches the modulo value an overflow flag sets. On the next timer tick the counter restarts from zero. The flag can drive an interrupt request through an enable bit. Software clears the flag by reading it while it is set and then writing zero to it.

Software reaches the block over a simple 8-bit address/data strobe bus. The modulo value is held as two byte registers. A write to the high byte starts an interlock that holds back overflow flagging and the interrupt until the low byte is written, so a half-updated modulo value cannot raise a spurious overflow. Software is expected to clear the counter with the self-clearing reset bit before it changes the modulo value.

Top module: `mod_timer`

## Requirements
- R1: After reset the modulo value is 0xFFFF, the counter is 0x0000, every control bit and the flag are 0, and irq is 0.
- R2: The counter increases by one on each clock where `tick` is 1 and the stop bit is 0. It holds on every other clock.
- R3: On the tick where the counter reaches the modulo value, the flag (control bit 7 at address 0) sets. The following tick loads 0x0000 into the counter.
- R4: The modulo value is read and written as bytes: address 3 holds bits 15:8 and address 4 holds bits 7:0.
- R5: A write to address 3 stops the flag from setting until a write to address 4. While this interlock is open, `irq` is held at 0.
- R6: `irq` is 1 exactly when the flag is 1, the interrupt enable (control bit 6) is 1, and no interlock is open.
- R7: The flag clears only when a control read sees the flag set and a later control write has bit 7 = 0. Any control write disarms the clear. A write with no arming read leaves the flag set.
- R8: While the stop bit (control bit 5) is 1, ticks do not change the counter. The flag and the modulo value also stay unchanged.
- R9: Writing 1 to control bit 4 clears the counter to 0x0000. Bit 4 reads back as 0.
- R10: The counter bytes at address 1 (bits 15:8) and address 2 (bits 7:0) are read-only, so writes to them are ignored. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer-clock enable |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (used to arm the flag clear) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counter is run with `tick` high and with `tick` low, to separate counting on the enable from counting on every clock. Wrap is tried with a small modulo value, checking both the count at the flag-setting tick and the zero that follows, which distinguishes wrap-at-modulo from wrap-one-late. The flag clear is tried with a write after an arming read and with a write after only a write, which tells a proper read-then-write from a bare write. The interlock is tried across a complete wrap, and again with the flag already set and the enable on, which separates blocking the flag from blocking only `irq`.

// File: rtl/mod_timer.sv
module mod_timer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt, modv, nxt;
  logic flag, arm, ie, stop, lock;
  logic ctrl_wr, clr_req, run, flag_set, flag_clr;

  assign ctrl_wr  = wr_en && addr == AW'(0);
  assign clr_req  = ctrl_wr && wdata[4];
  assign run      = tick && !stop;
  assign nxt      = (cnt == modv) ? '0 : cnt + CW'(1);
  assign flag_set = run && !clr_req && !lock && nxt == modv;
  assign flag_clr = ctrl_wr && arm && !wdata[7];
  assign irq      = flag && ie && !lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (clr_req) cnt <= '0;
    else if (run) cnt <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      modv <= '1;
      lock <= 1'b0;
    end else if (wr_en && addr == AW'(3)) begin
      modv[CW-1:DW] <= wdata;
      lock <= 1'b1;
    end else if (wr_en && addr == AW'(4)) begin
      modv[DW-1:0] <= wdata;
      lock <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0;
      arm  <= 1'b0;
      ie   <= 1'b0;
      stop <= 1'b0;
    end else begin
      flag <= flag_set || (flag && !flag_clr);
      if (ctrl_wr) begin
        arm  <= 1'b0;
        ie   <= wdata[6];
        stop <= wdata[5];
      end else if (rd_en && addr == AW'(0) && flag) begin
        arm <= 1'b1;
      end
    end

  always_comb
    case (addr)
      AW'(0):  rdata = {flag, ie, stop, {(DW-3){1'b0}}};
      AW'(1):  rdata = cnt[CW-1:DW];
      AW'(2):  rdata = cnt[DW-1:0];
      AW'(3):  rdata = modv[CW-1:DW];
      AW'(4):  rdata = modv[DW-1:0];
      default: rdata = '0;
    endcase

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clr_req && cnt != modv |=> cnt == $past(cnt) + CW'(1));
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clr_req && cnt == modv |=> cnt == '0);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !flag |=> !flag);
  a_r6_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag && ie);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !ctrl_wr |=> flag);
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !clr_req |=> $stable(cnt));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> cnt == '0);
endmodule

// File: tb/sim_mod_timer.sv
module sim_mod_timer;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0, irq;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int checks = 0, fails = 0;

  mod_timer u0 (.clk, .rst_n, .tick, .wr_en, .rd_en, .addr, .wdata, .rdata, .irq);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd_cnt(output int c);
    logic [7:0] h, l;
    rd(1, h); rd(2, l); c = {h, l};
  endtask

  task automatic set_mod(input logic [15:0] m);
    wr(3, m[15:8]); wr(4, m[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d; int c;
    rd(3, d); chk("R1 mod hi", d, 8'hFF);
    rd(4, d); chk("R1 mod lo", d, 8'hFF);
    rd_cnt(c); chk("R1 counter", c, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count;
    int c;
    ticks(5); rd_cnt(c); chk("R2 count on tick", c, 5);
    repeat (3) @(negedge clk);
    rd_cnt(c); chk("R2 hold without tick", c, 5);
  endtask

  task automatic t_modbytes;
    logic [7:0] d;
    wr(0, 8'h10);
    set_mod(16'h0003);
    rd(3, d); chk("R4 mod hi", d, 8'h00);
    rd(4, d); chk("R4 mod lo", d, 8'h03);
  endtask

  task automatic t_wrap;
    logic [7:0] d; int c;
    ticks(3); rd_cnt(c); chk("R3 at modulo", c, 3);
    rd(0, d); chk("R3 flag set", d[7], 1);
    ticks(1); rd_cnt(c); chk("R3 restart at zero", c, 0);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(0, 8'h80); wr(0, 8'h00);
    rd(0, d); chk("R7 write without arming read keeps flag", d[7], 1);
    wr(0, 8'h00);
    rd(0, d); chk("R7 read then write zero clears", d[7], 0);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(0, 8'h50);
    chk("R6 irq low before overflow", irq, 0);
    ticks(3);
    chk("R6 irq with flag and enable", irq, 1);
    wr(3, 8'h00);
    chk("R5 irq masked by interlock", irq, 0);
    wr(4, 8'h03);
    chk("R6 irq after interlock closes", irq, 1);
    rd(0, d); wr(0, 8'h00);
    chk("R6 irq low when enable off", irq, 0);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    wr(0, 8'h50);
    wr(3, 8'h00);
    ticks(4);
    rd(0, d); chk("R5 no flag while interlock open", d[7], 0);
    chk("R5 no irq while interlock open", irq, 0);
    wr(4, 8'h03);
    ticks(3);
    rd(0, d); chk("R5 flag after low byte", d[7], 1);
    wr(0, 8'h00);
  endtask

  task automatic t_stop;
    logic [7:0] d; int c;
    wr(0, 8'h10);
    ticks(2);
    wr(0, 8'h20);
    ticks(5);
    rd_cnt(c); chk("R8 counter frozen", c, 2);
    rd(0, d); chk("R8 flag unchanged", d[7], 0);
    rd(4, d); chk("R8 modulo unchanged", d, 8'h03);
    wr(0, 8'h00);
  endtask

  task automatic t_clr;
    logic [7:0] d; int c;
    set_mod(16'h00FF);
    ticks(9);
    wr(0, 8'h10);
    rd_cnt(c); chk("R9 counter cleared", c, 0);
    rd(0, d); chk("R9 clear bit reads 0", d[4], 0);
  endtask

  task automatic t_ro;
    logic [7:0] d; int c;
    ticks(7);
    wr(1, 8'hAA); wr(2, 8'h55);
    rd_cnt(c); chk("R10 counter write ignored", c, 7);
    rd(6, d); chk("R10 unused address reads 0", d, 0);
  endtask

  initial begin
    #20 rst_n = 1;
    t_reset; t_count; t_modbytes; t_wrap; t_clear;
    t_irq; t_lock; t_stop; t_clr; t_ro;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule